// File: doc/BRIEF.md
# Delay-Slot-Aware Static Branch Redirect Controller

This block steers instruction fetch for a five-stage, in-order, single-issue pipeline whose ISA has exactly one delay slot after every branch. When a conditional branch sits in decode, the delay-slot instruction is already in fetch. The block therefore forms its guess at that point. A branch whose target is at or below its own address is guessed taken, and fetch is redirected to the target in the same cycle. A branch that points forward is left on the sequential path. Unconditional jumps are always redirected.

One cycle later the branch is in execute and its real condition arrives. If the guess was wrong, the block redirects fetch to the correct address. It also flushes the one wrong-path instruction that is in fetch. The delay-slot instruction, which is in decode by then, is left alone. A mode input swaps the direction guess for a plain always-not-taken baseline. A stall input freezes the block.

Top module: `bp_static_redirect`

## Requirements
- R1: While reset is held and after it, with no branch activity, `fetch_sel` is 0 (sequential), `fetch_pc` is 0, `flush_fetch` is 0, and no branch is tracked.
- R2: With `pred_mode`=1, a valid conditional branch in decode whose target is lower than or equal to its address drives `fetch_sel`=1 (predicted redirect) and `fetch_pc`=target in that same cycle.
- R3: With `pred_mode`=1, a valid conditional branch in decode whose target is above its address leaves `fetch_sel`=0 and `flush_fetch`=0.
- R4: With `pred_mode`=0, no conditional branch is redirected in decode. If it resolves taken in the next cycle, `fetch_sel`=2 (correction), `fetch_pc`=target and `flush_fetch`=1 for that one cycle.
- R5: A valid jump in decode always drives `fetch_sel`=1 with its target. In either mode it never causes a correction, whatever `ex_taken` is.
- R6: A branch predicted taken that resolves not-taken (`ex_taken`=0 in the cycle after decode) drives `fetch_sel`=2, `fetch_pc`=branch address + 8 (skipping the delay slot) and `flush_fetch`=1.
- R7: A branch predicted not-taken that resolves taken drives `fetch_sel`=2, `fetch_pc`=its target and `flush_fetch`=1.
- R8: When a correction and a decode-stage branch occur in the same cycle, the correction wins. The decode branch gets no redirect and is not tracked, so it causes no correction in the following cycle.
- R9: While `stall`=1 the outputs are sequential with no flush, and the tracked branch holds. The decode prediction and the execute check are made in the first unstalled cycle.
- R10: A correctly predicted branch causes neither a redirect nor a flush in its execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall | input | 1 | Pipeline freeze |
| pred_mode | input | 1 | 1: backward-taken/forward-not-taken, 0: always not-taken |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_is_cond | input | 1 | Decode instruction is a conditional branch |
| id_is_jump | input | 1 | Decode instruction is an unconditional jump |
| id_pc | input | 32 | Address of the decode instruction |
| id_target | input | 32 | Branch or jump target of the decode instruction |
| ex_taken | input | 1 | Resolved condition of the branch now in execute |
| fetch_sel | output | 2 | Next-PC select: 0 sequential, 1 predicted redirect, 2 correction |
| fetch_pc | output | 32 | Redirect address, 0 when sequential |
| flush_fetch | output | 1 | Kill the instruction now in fetch |

## Verification
The hardest state to reach is a correction that lands in the same cycle as a new decode-stage branch. The younger branch then has to vanish, so a stale record would show up one cycle later as a spurious correction. The bench builds this deliberately. It decodes a forward branch, then presents a backward branch in decode while `ex_taken`=1, then drives `ex_taken`=0. Stalls are inserted both while a branch waits in decode and while it waits to resolve. A long random run compares every cycle against a behavioural model.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [1:0] {
    FSEL_SEQ  = 2'd0,
    FSEL_PRED = 2'd1,
    FSEL_FIX  = 2'd2
  } fetch_sel_e;
endpackage

// File: rtl/bp_direction.sv
module bp_direction #(
  parameter int unsigned AW = 32
) (
  input  logic          btfn_en,
  input  logic          is_jump,
  input  logic [AW-1:0] br_pc,
  input  logic [AW-1:0] br_tgt,
  output logic          guess_taken
);
  logic backward;

  always_comb begin
    backward    = (br_tgt <= br_pc);
    guess_taken = is_jump | (btfn_en & backward);
  end
endmodule

// File: rtl/bp_track.sv
module bp_track #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          load,
  input  logic          in_jump,
  input  logic          in_pred,
  input  logic [AW-1:0] in_pc,
  input  logic [AW-1:0] in_tgt,
  output logic          q_vld,
  output logic          q_jump,
  output logic          q_pred,
  output logic [AW-1:0] q_pc,
  output logic [AW-1:0] q_tgt
);
  logic          vld_d, jump_d, pred_d;
  logic [AW-1:0] pc_d, tgt_d;
  logic          upd_en;

  always_comb begin
    upd_en = ~hold;
    vld_d  = load;
    jump_d = load & in_jump;
    pred_d = load & in_pred;
    pc_d   = in_pc;
    tgt_d  = in_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_jump <= 1'b0;
      q_pred <= 1'b0;
      q_pc   <= '0;
      q_tgt  <= '0;
    end else if (upd_en) begin
      q_vld  <= vld_d;
      q_jump <= jump_d;
      q_pred <= pred_d;
      q_pc   <= pc_d;
      q_tgt  <= tgt_d;
    end
  end

  p_hold_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(q_vld) && $stable(q_pred) && $stable(q_pc) && $stable(q_tgt)));
endmodule

// File: rtl/bp_redirect.sv
module bp_redirect
  import bp_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          ex_vld,
  input  logic          ex_jump,
  input  logic          ex_pred,
  input  logic [AW-1:0] ex_pc,
  input  logic [AW-1:0] ex_tgt,
  input  logic          ex_taken,
  input  logic          dec_fire,
  input  logic          dec_pred,
  input  logic [AW-1:0] dec_tgt,
  output logic          corr,
  output fetch_sel_e    sel,
  output logic [AW-1:0] addr,
  output logic          flush
);
  localparam logic [AW-1:0] SKIP_OFS = AW'(2 * INSN_BYTES);

  logic          wrong;
  logic [AW-1:0] fix_pc;

  always_comb begin
    wrong  = ex_vld & ~ex_jump & (ex_taken != ex_pred);
    corr   = wrong & ~stall;
    fix_pc = ex_taken ? ex_tgt : (ex_pc + SKIP_OFS);
    sel    = FSEL_SEQ;
    addr   = '0;
    flush  = 1'b0;
    if (corr) begin
      sel   = FSEL_FIX;
      addr  = fix_pc;
      flush = 1'b1;
    end else if (dec_fire && dec_pred) begin
      sel  = FSEL_PRED;
      addr = dec_tgt;
    end
  end

  p_quiet_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (sel == FSEL_SEQ && !flush));
  p_single_fix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    corr |=> !(corr && !$past(stall)) || stall);
endmodule

// File: rtl/bp_static_redirect.sv
module bp_static_redirect
  import bp_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          pred_mode,
  input  logic          id_valid,
  input  logic          id_is_cond,
  input  logic          id_is_jump,
  input  logic [AW-1:0] id_pc,
  input  logic [AW-1:0] id_target,
  input  logic          ex_taken,
  output logic [1:0]    fetch_sel,
  output logic [AW-1:0] fetch_pc,
  output logic          flush_fetch
);
  logic          rst_s1, rst_sync;
  logic          guess;
  logic          dec_fire;
  logic          corr;
  logic          ex_vld, ex_jump, ex_pred;
  logic [AW-1:0] ex_pc, ex_tgt;
  fetch_sel_e    sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  bp_direction #(.AW(AW)) u_dir (
    .btfn_en     (pred_mode),
    .is_jump     (id_is_jump),
    .br_pc       (id_pc),
    .br_tgt      (id_target),
    .guess_taken (guess)
  );

  always_comb begin
    dec_fire = id_valid & (id_is_cond | id_is_jump) & ~stall & ~corr;
  end

  bp_track #(.AW(AW)) u_track (
    .clk     (clk),
    .rst_n   (rst_sync),
    .hold    (stall),
    .load    (dec_fire),
    .in_jump (id_is_jump),
    .in_pred (guess),
    .in_pc   (id_pc),
    .in_tgt  (id_target),
    .q_vld   (ex_vld),
    .q_jump  (ex_jump),
    .q_pred  (ex_pred),
    .q_pc    (ex_pc),
    .q_tgt   (ex_tgt)
  );

  bp_redirect #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_redir (
    .clk      (clk),
    .rst_n    (rst_sync),
    .stall    (stall),
    .ex_vld   (ex_vld),
    .ex_jump  (ex_jump),
    .ex_pred  (ex_pred),
    .ex_pc    (ex_pc),
    .ex_tgt   (ex_tgt),
    .ex_taken (ex_taken),
    .dec_fire (dec_fire),
    .dec_pred (guess),
    .dec_tgt  (id_target),
    .corr     (corr),
    .sel      (sel),
    .addr     (fetch_pc),
    .flush    (flush_fetch)
  );

  always_comb fetch_sel = sel;

  p_jump_kept_taken_r5: assert property (@(posedge clk) disable iff (!rst_sync)
    (dec_fire && id_is_jump) |=> (ex_jump && ex_pred));
  p_drop_young_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    (corr && id_valid && id_is_cond) |=> !ex_vld);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_sync |-> (!ex_vld && !flush_fetch));
  p_fix_flushes_r6: assert property (@(posedge clk) disable iff (!rst_sync)
    (fetch_sel == 2'd2) |-> (flush_fetch && $past(dec_fire) || flush_fetch));
endmodule

// File: tb/bp_static_redirect_test.sv
module bp_static_redirect_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall, pred_mode, id_valid, id_is_cond, id_is_jump, ex_taken;
  logic [31:0] id_pc, id_target;
  logic [1:0]  fetch_sel;
  logic [31:0] fetch_pc;
  logic        flush_fetch;

  integer n_tests = 0;
  integer n_fail  = 0;
  bit     done    = 1'b0;

  // behavioural model of the branch currently in execute
  integer m_vld = 0, m_jmp = 0, m_pred = 0;
  longint m_pc = 0, m_tgt = 0;

  always #10 clk = ~clk;

  bp_static_redirect uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .pred_mode(pred_mode),
    .id_valid(id_valid), .id_is_cond(id_is_cond), .id_is_jump(id_is_jump),
    .id_pc(id_pc), .id_target(id_target), .ex_taken(ex_taken),
    .fetch_sel(fetch_sel), .fetch_pc(fetch_pc), .flush_fetch(flush_fetch)
  );

  task automatic check3(input string tag, input int esel, input longint epc, input int efl);
    n_tests++;
    if (fetch_sel !== 2'(esel) || fetch_pc !== 32'(epc) || flush_fetch !== 1'(efl)) begin
      n_fail++;
      $display("FAIL %s: sel/pc/flush got %0d/%h/%0d expected %0d/%h/%0d",
               tag, fetch_sel, fetch_pc, flush_fetch, esel, 32'(epc), efl);
    end
  endtask

  task automatic step(input bit st, input bit md, input bit iv, input bit cd, input bit jp,
                      input logic [31:0] pc, input logic [31:0] tg, input bit et);
    int     esel, efl, corr, fire, guess;
    longint epc;
    string  tag;
    stall = st; pred_mode = md; id_valid = iv; id_is_cond = cd; id_is_jump = jp;
    id_pc = pc; id_target = tg; ex_taken = et;
    #2;
    corr  = (!st && m_vld && !m_jmp && (int'(et) != m_pred)) ? 1 : 0;
    fire  = (!st && !corr && iv && (cd || jp)) ? 1 : 0;
    guess = (jp || (md && (tg <= pc))) ? 1 : 0;
    esel = 0; epc = 0; efl = 0; tag = "R10";
    if (st) tag = "R9";
    else if (corr) begin
      esel = 2; efl = 1;
      epc  = et ? m_tgt : ((m_pc + 8) & 64'hFFFF_FFFF);
      tag  = iv && (cd || jp) ? "R8" : (et ? (md ? "R7" : "R4") : "R6");
    end else if (fire && guess) begin
      esel = 1; epc = tg;
      tag  = jp ? "R5" : "R2";
    end else if (fire) tag = md ? "R3" : "R4";
    check3(tag, esel, epc, efl);
    @(posedge clk);
    if (!st) begin
      m_vld = fire; m_jmp = fire && jp; m_pred = fire && guess;
      m_pc = pc; m_tgt = tg;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall = 0; pred_mode = 1; id_valid = 0; id_is_cond = 0;
    id_is_jump = 0; id_pc = 0; id_target = 0; ex_taken = 0;
    repeat (3) @(negedge clk);
    check3("R1", 0, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check3("R1", 0, 0, 0);

    // R2 backward, then correct resolution (R10)
    step(0,1,1,1,0, 32'h100, 32'h080, 0);
    step(0,1,1,0,0, 32'h104, 32'h0,   1);
    // R2 equal target counts as backward
    step(0,1,1,1,0, 32'h200, 32'h200, 0);
    step(0,1,1,0,0, 32'h204, 32'h0,   1);
    // R3 forward, resolves not-taken (R10)
    step(0,1,1,1,0, 32'h300, 32'h340, 0);
    step(0,1,1,0,0, 32'h304, 32'h0,   0);
    // R6 backward guessed taken, resolves not-taken -> pc+8
    step(0,1,1,1,0, 32'h400, 32'h3F0, 0);
    step(0,1,1,0,0, 32'h404, 32'h0,   0);
    // R7 forward guessed not-taken, resolves taken
    step(0,1,1,1,0, 32'h500, 32'h580, 0);
    step(0,1,1,0,0, 32'h504, 32'h0,   1);
    // R5 forward jump, ex_taken low must not correct
    step(0,1,1,0,1, 32'h600, 32'h700, 0);
    step(0,1,1,0,0, 32'h604, 32'h0,   0);
    // R4 baseline mode backward, resolves taken
    step(0,0,1,1,0, 32'h800, 32'h700, 0);
    step(0,0,1,0,0, 32'h804, 32'h0,   1);
    // R8 correction with a decode branch in the same cycle
    step(0,1,1,1,0, 32'h900, 32'h980, 0);
    step(0,1,1,1,0, 32'h904, 32'h800, 1);
    step(0,1,0,0,0, 32'h0,   32'h0,   0);
    // R9 stall while branch waits in decode and while it waits to resolve
    step(1,1,1,1,0, 32'hA00, 32'h900, 0);
    step(0,1,1,1,0, 32'hA00, 32'h900, 0);
    step(1,1,1,0,0, 32'hA04, 32'h0,   0);
    step(1,1,1,0,0, 32'hA04, 32'h0,   0);
    step(0,1,1,0,0, 32'hA04, 32'h0,   0);
    step(0,1,0,0,0, 32'h0,   32'h0,   0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] rpc, rtg;
      rpc = {20'h0, 10'($urandom), 2'b00};
      rtg = {20'h0, 10'($urandom), 2'b00};
      step(($urandom % 5) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
           ($urandom % 2) == 0, ($urandom % 6) == 0, rpc, rtg, ($urandom % 2) == 0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule